// File: doc/BRIEF.md
# Hibernate Wakeup and Reset Sequencer

An always-on power sequencer that runs from the slow real-time clock. Software programs two coarse durations, then asks the block to sleep. While asleep, the block watches a wakeup pin and takes a wakeup only once the pin has stayed high for the programmed minimum hold time. Shorter pulses are discarded, and the hold measurement starts again from zero.

Once a wakeup is taken, the block holds an active-low system reset for the programmed pulse length and then returns to idle. Both durations are set in steps of 32 ticks. The four registers survive sleep and are cleared only by the power-on reset.

Writes cross into a slow domain. A ready flag therefore drops for two ticks after each accepted write, and any write offered while the flag is low is lost. A two-bit state output reports idle, sleep or reset-pulse.

Top module: `hib_wake_seq`

## Requirements
- R1: While `por_n` is low and right after it rises: `seq_state` is 0 (idle), `sys_rst_n` is 1, the control register (offset 0x00) reads 0x80, and the registers at offsets 0x20, 0x24 and 0x28 read 0.
- R2: Bit 7 of the control register at offset 0x00 is the write-ready flag. It reads 1 when no write is pending. After an accepted write it reads 0 for exactly 2 clock cycles and then reads 1 again.
- R3: A write offered while the write-ready flag is 0 is dropped and leaves every register unchanged.
- R4: A write to offset 0x20 with bit 0 set, accepted while idle, moves `seq_state` to 1 (sleep) at the same clock edge. A write there with bit 0 clear has no effect. Bit 0 of offset 0x20 reads 1 exactly while the state is sleep.
- R5: Offset 0x24 holds a wakeup hold field in bits 15:5. Other bits are ignored when written and read back as 0. The required hold time is the field value times 32 cycles.
- R6: Offset 0x28 holds a reset-length field in bits 11:5. Other bits are ignored when written and read back as 0. The pulse length is the field value times 32 cycles.
- R7: In sleep, a wakeup is taken at the N-th consecutive rising edge at which `wake_in` is high, where N is the hold time, or 1 when the hold time is 0. The state then leaves sleep on that edge.
- R8: If `wake_in` is low at any edge while asleep, the hold count restarts from zero, so a run shorter than N causes no wakeup.
- R9: After a wakeup with a nonzero pulse length P, `seq_state` is 2 and `sys_rst_n` is 0 for exactly P cycles, then the state is idle and `sys_rst_n` is 1. With P equal to 0, the block goes straight to idle and `sys_rst_n` never drops.
- R10: `wake_in` has no effect while idle or during the reset pulse.
- R11: The programmed fields keep their values through a full sleep, wakeup and reset-pulse round trip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Real-time-domain clock |
| por_n | input | 1 | Active-low power-on reset, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Register write byte offset |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 6 | Register read byte offset |
| rd_data | output | 32 | Register read data (combinational) |
| wake_in | input | 1 | Wakeup pin, active high |
| sys_rst_n | output | 1 | Active-low system reset |
| seq_state | output | 2 | 0 idle, 1 sleep, 2 reset pulse |

## Verification
The bench aims at the hold threshold. It sends a wakeup run one cycle short of the hold time, then a full run. A filter that does not restart would wake early, and an off-by-one comparator would wake a cycle late or early.

It measures the reset pulse length in cycles, including zero-length pulses. A timer that does not stop at one would stretch the pulse, and a design that fails to skip a zero length would pull reset low anyway.

It offers a second write during the two busy cycles, and writes junk into the ignored low bits of both duration fields. A missing drop gate, or a field that was not masked, would then show up in readback or in the measured times.

// File: rtl/pws_pkg.sv
package pws_pkg;
    typedef enum logic [1:0] {
        PWS_IDLE  = 2'd0,
        PWS_SLEEP = 2'd1,
        PWS_PULSE = 2'd2
    } pws_state_e;

    localparam int OFS_CTRL  = 'h00;
    localparam int OFS_HIB   = 'h20;
    localparam int OFS_WFILT = 'h24;
    localparam int OFS_RCNT  = 'h28;
    localparam int RDY_BIT   = 7;
endpackage

// File: rtl/pws_regs.sv
module pws_regs
    import pws_pkg::*;
#(
    parameter int ADDR_W     = 6,
    parameter int DATA_W     = 32,
    parameter int STEP_LSB   = 5,
    parameter int FILT_MSB   = 15,
    parameter int RCNT_MSB   = 11,
    parameter int WRDY_TICKS = 2
) (
    input  logic                         clk,
    input  logic                         por_n,
    input  logic                         wr_en,
    input  logic [ADDR_W-1:0]            wr_addr,
    input  logic [DATA_W-1:0]            wr_data,
    input  logic [ADDR_W-1:0]            rd_addr,
    output logic [DATA_W-1:0]            rd_data,
    input  logic                         sleep_active,
    output logic                         hib_req,
    output logic [FILT_MSB-STEP_LSB:0]   filt_field,
    output logic [RCNT_MSB-STEP_LSB:0]   rcnt_field,
    output logic                         wrdy
);
    localparam int FILT_W = FILT_MSB - STEP_LSB + 1;
    localparam int RCNT_W = RCNT_MSB - STEP_LSB + 1;
    localparam int BUSY_W = $clog2(WRDY_TICKS + 1);

    typedef struct packed {
        logic [FILT_W-1:0] filt;
        logic [RCNT_W-1:0] rcnt;
        logic [BUSY_W-1:0] busy;
    } regs_t;

    regs_t q, d;
    logic  wr_ok;
    logic  unused_wdata;

    assign unused_wdata = ^{wr_data[DATA_W-1:FILT_MSB+1], wr_data[STEP_LSB-1:1]};

    always_comb begin
        wrdy    = (q.busy == '0);
        wr_ok   = wr_en && wrdy;
        hib_req = wr_ok && (wr_addr == ADDR_W'(OFS_HIB)) && wr_data[0];
        d = q;
        if (q.busy != '0)
            d.busy = q.busy - 1'b1;
        if (wr_ok) begin
            d.busy = BUSY_W'(WRDY_TICKS);
            if (wr_addr == ADDR_W'(OFS_WFILT))
                d.filt = wr_data[FILT_MSB:STEP_LSB];
            if (wr_addr == ADDR_W'(OFS_RCNT))
                d.rcnt = wr_data[RCNT_MSB:STEP_LSB];
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(OFS_CTRL))
            rd_data[RDY_BIT] = wrdy;
        else if (rd_addr == ADDR_W'(OFS_HIB))
            rd_data[0] = sleep_active;
        else if (rd_addr == ADDR_W'(OFS_WFILT))
            rd_data[FILT_MSB:STEP_LSB] = q.filt;
        else if (rd_addr == ADDR_W'(OFS_RCNT))
            rd_data[RCNT_MSB:STEP_LSB] = q.rcnt;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) q <= '0;
        else        q <= d;
    end

    assign filt_field = q.filt;
    assign rcnt_field = q.rcnt;

    // R3: a write offered while busy changes no stored field
    assert_drop_busy_R3: assert property (@(posedge clk) disable iff (!por_n)
        (wr_en && !wrdy) |=> ($stable(q.filt) && $stable(q.rcnt)));

    // R2: an accepted write makes the ready flag low on the next cycle
    assert_busy_after_write_R2: assert property (@(posedge clk) disable iff (!por_n)
        (wr_en && wrdy) |=> !wrdy);
endmodule

// File: rtl/pws_wake_filt.sv
module pws_wake_filt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             arm,
    input  logic             wake_in,
    input  logic [CNT_W-1:0] need_ticks,
    output logic             accept
);
    typedef struct packed {
        logic [CNT_W-1:0] run;
    } filt_t;

    filt_t q, d;

    always_comb begin
        accept = arm && wake_in &&
                 (({1'b0, q.run} + (CNT_W+1)'(1)) >= {1'b0, need_ticks});
        d = q;
        if (arm && wake_in && !accept)
            d.run = q.run + 1'b1;
        else
            d.run = '0;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) q <= '0;
        else        q <= d;
    end

    // R8: a low pin while armed restarts the hold count
    assert_restart_R8: assert property (@(posedge clk) disable iff (!por_n)
        (arm && !wake_in) |=> (q.run == '0));

    // R7: a high pin below threshold advances the count by one
    assert_count_up_R7: assert property (@(posedge clk) disable iff (!por_n)
        (arm && wake_in && !accept) |=> (q.run == $past(q.run) + 1'b1));
endmodule

// File: rtl/pws_ctrl.sv
module pws_ctrl
    import pws_pkg::*;
#(
    parameter int TMR_W = 12
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             hib_req,
    input  logic             accept,
    input  logic [TMR_W-1:0] pulse_ticks,
    output pws_state_e       state_o,
    output logic             sys_rst_n
);
    typedef struct packed {
        pws_state_e       st;
        logic [TMR_W-1:0] tmr;
    } ctrl_t;

    ctrl_t q, d;

    always_comb begin
        d = q;
        case (q.st)
            PWS_IDLE: begin
                if (hib_req) d.st = PWS_SLEEP;
            end
            PWS_SLEEP: begin
                if (accept) begin
                    if (pulse_ticks == '0) begin
                        d.st = PWS_IDLE;
                    end else begin
                        d.st  = PWS_PULSE;
                        d.tmr = pulse_ticks;
                    end
                end
            end
            PWS_PULSE: begin
                if (q.tmr <= TMR_W'(1)) begin
                    d.st  = PWS_IDLE;
                    d.tmr = '0;
                end else begin
                    d.tmr = q.tmr - 1'b1;
                end
            end
            default: d.st = PWS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) q <= '{st: PWS_IDLE, tmr: '0};
        else        q <= d;
    end

    assign state_o   = q.st;
    assign sys_rst_n = (q.st != PWS_PULSE);

    // R4: a hibernate request while idle enters sleep
    assert_sleep_entry_R4: assert property (@(posedge clk) disable iff (!por_n)
        (q.st == PWS_IDLE && hib_req) |=> (q.st == PWS_SLEEP));

    // R10: idle is left only on a hibernate request
    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!por_n)
        (q.st == PWS_IDLE && !hib_req) |=> (q.st == PWS_IDLE));

    // R7: sleep is left only on an accepted wakeup
    assert_sleep_hold_R7: assert property (@(posedge clk) disable iff (!por_n)
        (q.st == PWS_SLEEP && !accept) |=> (q.st == PWS_SLEEP));

    // R9: the pulse continues while more than one tick remains
    assert_pulse_len_R9: assert property (@(posedge clk) disable iff (!por_n)
        (q.st == PWS_PULSE && q.tmr > TMR_W'(1)) |=> (q.st == PWS_PULSE));
endmodule

// File: rtl/hib_wake_seq.sv
module hib_wake_seq
    import pws_pkg::*;
#(
    parameter int ADDR_W     = 6,
    parameter int DATA_W     = 32,
    parameter int STEP_LSB   = 5,
    parameter int FILT_MSB   = 15,
    parameter int RCNT_MSB   = 11,
    parameter int WRDY_TICKS = 2
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wake_in,
    output logic              sys_rst_n,
    output logic [1:0]        seq_state
);
    localparam int FILT_W = FILT_MSB - STEP_LSB + 1;
    localparam int RCNT_W = RCNT_MSB - STEP_LSB + 1;
    localparam int CNT_W  = FILT_MSB + 1;
    localparam int TMR_W  = RCNT_MSB + 1;

    logic [FILT_W-1:0] filt_field;
    logic [RCNT_W-1:0] rcnt_field;
    logic              hib_req;
    logic              wrdy;
    logic              accept;
    pws_state_e        st;

    pws_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STEP_LSB(STEP_LSB),
        .FILT_MSB(FILT_MSB), .RCNT_MSB(RCNT_MSB), .WRDY_TICKS(WRDY_TICKS)
    ) i_regs (
        .clk(clk), .por_n(por_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .sleep_active(st == PWS_SLEEP), .hib_req(hib_req),
        .filt_field(filt_field), .rcnt_field(rcnt_field), .wrdy(wrdy)
    );

    pws_wake_filt #(.CNT_W(CNT_W)) i_filt (
        .clk(clk), .por_n(por_n), .arm(st == PWS_SLEEP), .wake_in(wake_in),
        .need_ticks({filt_field, {STEP_LSB{1'b0}}}), .accept(accept)
    );

    pws_ctrl #(.TMR_W(TMR_W)) i_ctrl (
        .clk(clk), .por_n(por_n), .hib_req(hib_req), .accept(accept),
        .pulse_ticks({rcnt_field, {STEP_LSB{1'b0}}}),
        .state_o(st), .sys_rst_n(sys_rst_n)
    );

    assign seq_state = st;

    // R1: the write-ready flag is high on the first cycle after power-on reset
    assert_ready_after_por_R1: assert property (@(posedge clk) disable iff (!por_n)
        $rose(por_n) |-> wrdy);
endmodule

// File: tb/test_hib_wake_seq.sv
module test_hib_wake_seq;
    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [5:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        wake_in = 1'b0;
    logic        sys_rst_n;
    logic [1:0]  seq_state;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    hib_wake_seq i_hib_wake_seq (
        .clk(clk), .por_n(por_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .wake_in(wake_in), .sys_rst_n(sys_rst_n), .seq_state(seq_state)
    );

    always #10 clk = ~clk;

    function automatic int exp_hold(input logic [31:0] v);
        int t = int'((v >> 5) & 32'h7FF) * 32;
        return (t == 0) ? 1 : t;
    endfunction

    function automatic int exp_pulse(input logic [31:0] v);
        return int'((v >> 5) & 32'h7F) * 32;
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] v);
        logic [31:0] c;
        rd(6'h00, c);
        while (!c[7]) begin
            @(negedge clk);
            rd(6'h00, c);
        end
        wr_addr = a;
        wr_data = v;
        wr_en   = 1'b1;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic round_trip(input logic [31:0] fv, input logic [31:0] rv, input bit hold_wake);
        logic [31:0] v;
        int need, plen, k, r;
        need = exp_hold(fv);
        plen = exp_pulse(rv);
        wr(6'h24, fv);
        wr(6'h28, rv);
        wr(6'h20, 32'h1);
        chk("R4 sleep entry", 32'(seq_state), 32'd1);
        rd(6'h20, v);
        chk("R4 hib readback asleep", v, 32'h1);
        if (need >= 2) begin
            wake_in = 1'b1;
            for (int i = 0; i < need - 1; i++) @(negedge clk);
            wake_in = 1'b0;
            @(negedge clk);
            chk("R8 short run rejected", 32'(seq_state), 32'd1);
        end
        wake_in = 1'b1;
        k = 0;
        do begin
            @(negedge clk);
            k++;
        end while (seq_state == 2'd1 && k < 5000);
        chk("R7 hold cycles", 32'(k), 32'(need));
        if (!hold_wake) wake_in = 1'b0;
        if (plen == 0) begin
            chk("R9 zero pulse state", 32'(seq_state), 32'd0);
            chk("R9 zero pulse reset", 32'(sys_rst_n), 32'd1);
        end else begin
            chk("R9 pulse state", 32'(seq_state), 32'd2);
            r = 0;
            while (sys_rst_n == 1'b0 && r < 5000) begin
                r++;
                @(negedge clk);
            end
            chk("R9 pulse cycles", 32'(r), 32'(plen));
        end
        repeat (3) @(negedge clk);
        chk("R10 idle after pulse", 32'(seq_state), 32'd0);
        wake_in = 1'b0;
        rd(6'h20, v);
        chk("R4 hib readback idle", v, 32'h0);
        rd(6'h24, v);
        chk("R5 R11 filter kept", v, fv & 32'h0000FFE0);
        rd(6'h28, v);
        chk("R6 R11 reset len kept", v, rv & 32'h00000FE0);
    endtask

    initial begin
        #3_000_000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        chk("R1 state in reset", 32'(seq_state), 32'd0);
        chk("R1 reset out in reset", 32'(sys_rst_n), 32'd1);
        por_n = 1'b1;
        @(negedge clk);
        rd(6'h00, v); chk("R1 ctrl", v, 32'h80);
        rd(6'h20, v); chk("R1 hib", v, 32'h0);
        rd(6'h24, v); chk("R1 filter", v, 32'h0);
        rd(6'h28, v); chk("R1 reset len", v, 32'h0);

        // R2 busy window and R3 dropped write
        wr(6'h24, 32'h0000_0040);
        rd(6'h00, v); chk("R2 busy cycle 1", v, 32'h0);
        wr_addr = 6'h24; wr_data = 32'h0000_FFE0; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        rd(6'h00, v); chk("R2 busy cycle 2", v, 32'h0);
        @(negedge clk);
        rd(6'h00, v); chk("R2 ready again", v, 32'h80);
        rd(6'h24, v); chk("R3 dropped write", v, 32'h40);

        // R4 write of zero, R10 pin while idle
        wr(6'h20, 32'h0);
        chk("R4 zero write ignored", 32'(seq_state), 32'd0);
        wake_in = 1'b1;
        repeat (5) @(negedge clk);
        chk("R10 pin idle state", 32'(seq_state), 32'd0);
        chk("R10 pin idle reset", 32'(sys_rst_n), 32'd1);
        wake_in = 1'b0;

        // R5 R6 ignored bits, directed thresholds
        round_trip(32'hFFFF_003F, 32'hFFFF_F05F, 1'b0);
        round_trip(32'h0000_001F, 32'h0000_001F, 1'b0);
        round_trip(32'h0000_0020, 32'h0000_0020, 1'b1);

        for (int t = 0; t < 10; t++) begin
            logic [31:0] fv, rv;
            fv = ($urandom() & 32'hFFFF_001F) | ((32'($urandom_range(0, 3))) << 5);
            rv = ($urandom() & 32'hFFFF_F01F) | ((32'($urandom_range(0, 2))) << 5);
            round_trip(fv, rv, t[0]);
        end
        finish_run();
    end
endmodule